// File: doc/BRIEF.md
# Nibble-Bus Memory Read Target

This block is the target side of a 4-bit multiplexed firmware memory bus. The host marks a transaction by pulling an active-low frame strobe while it places a start code on the nibble bus. It then sends a device select nibble, seven address nibbles and a size nibble. The target decodes this header and checks the select nibble against a strapped device ID. When the header is a supported single-byte memory read aimed at this device, the target takes the bus after a two-clock turnaround and answers with wait-sync codes, a ready-sync code, the data byte and a release nibble.

On the back end the captured 28-bit address goes to a plain byte-read memory port as a one-cycle request. The port answers with a valid strobe after any latency it needs. The target keeps sending wait-sync until that strobe has arrived and a minimum number of wait clocks has passed. The bus is modelled as separate input, output and output-enable signals, so the pad tri-state can be built at the chip edge.

Top module: `nbus_read_target`

## Requirements
- R1: A header starts only on clock edges where `frame_n` is low. While `frame_n` stays low, each edge replaces the stored start nibble, so only the nibble on the last low edge decides the cycle type. A nibble presented while `frame_n` is high never starts a cycle.
- R2: Only the start nibble 4'b1101 (memory read) is accepted. Any other start value leaves `bus_oe` low and `mem_req` low.
- R3: The nibble on the first edge with `frame_n` high after the start must equal `dev_id`. If it does not, the block never drives the bus and never requests memory.
- R4: The next seven nibbles form the address, most significant nibble first. One cycle after the edge that samples a good size nibble, `mem_req` is high for exactly one cycle and `mem_addr` carries that address.
- R5: The size nibble must be 4'b0000 (one byte). Any other value aborts the cycle with no request and no drive.
- R6: In the cycle after the size edge, the bus is left to the host (`bus_oe` low). In the cycle after that, the block enables its driver and drives 4'b1111.
- R7: After the turnaround, the block drives the wait-sync code 4'b0101 for at least `MIN_WAIT` cycles. It keeps doing so until `mem_valid` has been sampled high.
- R8: After the last wait-sync, the block drives the ready-sync code 4'b0000 for one cycle. It then drives the low data nibble and then the high data nibble.
- R9: After the high data nibble, the block drives 4'b1111 for one cycle and then lowers `bus_oe`. `bus_oe` is low in every cycle outside a response.
- R10: While and right after reset, `bus_oe` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, all fields sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| bus_in | input | 4 | Nibble bus as seen at the pad |
| bus_out | output | 4 | Nibble the target drives |
| bus_oe | output | 1 | Output enable for the pad driver |
| dev_id | input | 4 | Strapped device ID |
| mem_req | output | 1 | One-cycle read request to the memory port |
| mem_addr | output | 28 | Read address, valid with `mem_req` |
| mem_valid | input | 1 | Memory data valid strobe |
| mem_data | input | 8 | Byte returned by memory |

## Verification
The request is due one cycle after the edge that samples the size nibble. The turnaround drive comes one cycle after the request, and wait-sync starts the cycle after that. With edge k as the size edge, ready-sync is due in the cycle after edge max(k+2+MIN_WAIT, k+1+latency), and the data and release nibbles follow it one cycle apart. For every accepted header, the bench enters each of these cycle numbers in a schedule keyed by its absolute cycle count. It compares outputs one nanosecond after each rising edge, and any cycle missing from the schedule must show the bus released and no request.

// File: rtl/nbt_pkg.sv
`timescale 1ns/1ps
package nbt_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_SIZE, S_TAR0, S_TAR1,
        S_WAIT, S_RSYNC, S_DLO, S_DHI, S_TOUT
    } nbt_state_e;

    localparam logic [3:0] CODE_READ  = 4'b1101;
    localparam logic [3:0] SYNC_WAIT  = 4'b0101;
    localparam logic [3:0] SYNC_READY = 4'b0000;
    localparam logic [3:0] NIB_IDLE   = 4'b1111;
    localparam logic [3:0] SIZE_ONE   = 4'b0000;
endpackage

// File: rtl/nbt_addr_shift.sv
`timescale 1ns/1ps
module nbt_addr_shift #(
    parameter int NIBS = 7,
    localparam int AW = 4 * NIBS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic [3:0]    nib,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (shift_en) addr_d = {addr_q[AW-5:0], nib};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;
endmodule

// File: rtl/nbt_wait_timer.sv
`timescale 1ns/1ps
module nbt_wait_timer #(
    parameter int MIN_WAIT = 2,
    localparam int CW = $clog2(MIN_WAIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic min_met
);
    logic [CW-1:0] cnt_d, cnt_q;

    assign min_met = (cnt_q >= CW'(MIN_WAIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!run)          cnt_d = '0;
        else if (!min_met) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7: the wait counter never runs past its limit
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= CW'(MIN_WAIT - 1)));
endmodule

// File: rtl/nbt_bus_drive.sv
`timescale 1ns/1ps
module nbt_bus_drive
    import nbt_pkg::*;
(
    input  nbt_state_e st,
    input  logic [7:0] data,
    output logic       oe,
    output logic [3:0] nib
);
    always_comb begin
        oe  = 1'b1;
        nib = NIB_IDLE;
        case (st)
            S_TAR1:  nib = NIB_IDLE;
            S_WAIT:  nib = SYNC_WAIT;
            S_RSYNC: nib = SYNC_READY;
            S_DLO:   nib = data[3:0];
            S_DHI:   nib = data[7:4];
            S_TOUT:  nib = NIB_IDLE;
            default: oe  = 1'b0;
        endcase
    end
endmodule

// File: rtl/nbus_read_target.sv
`timescale 1ns/1ps
module nbus_read_target
    import nbt_pkg::*;
#(
    parameter int ADDR_NIBS = 7,
    parameter int MIN_WAIT  = 2,
    localparam int AW = 4 * ADDR_NIBS,
    localparam int IW = $clog2(ADDR_NIBS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_n,
    input  logic [3:0]    bus_in,
    output logic [3:0]    bus_out,
    output logic          bus_oe,
    input  logic [3:0]    dev_id,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_valid,
    input  logic [7:0]    mem_data
);
    typedef struct packed {
        nbt_state_e  st;
        logic        start_ok;
        logic [IW-1:0] idx;
        logic        req;
        logic        got;
        logic [7:0]  data;
    } regs_t;

    regs_t r_d, r_q;
    logic  shift_en;
    logic  min_met;
    logic  decoding;

    nbt_addr_shift #(.NIBS(ADDR_NIBS)) u_addr (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .nib(bus_in), .addr(mem_addr)
    );

    nbt_wait_timer #(.MIN_WAIT(MIN_WAIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(r_q.st == S_WAIT), .min_met(min_met)
    );

    nbt_bus_drive u_drive (
        .st(r_q.st), .data(r_q.data), .oe(bus_oe), .nib(bus_out)
    );

    assign decoding = (r_q.st == S_IDLE) || (r_q.st == S_ADDR) ||
                      (r_q.st == S_SIZE) || (r_q.st == S_TAR0);

    always_comb begin
        r_d      = r_q;
        r_d.req  = 1'b0;
        shift_en = 1'b0;

        if ((r_q.st == S_TAR0 || r_q.st == S_TAR1 || r_q.st == S_WAIT) &&
            mem_valid && !r_q.got) begin
            r_d.got  = 1'b1;
            r_d.data = mem_data;
        end

        if (!frame_n && decoding) begin
            r_d.st       = S_IDLE;
            r_d.start_ok = (bus_in == CODE_READ);
        end else begin
            case (r_q.st)
                S_IDLE: begin
                    if (r_q.start_ok) begin
                        r_d.start_ok = 1'b0;
                        if (bus_in == dev_id) begin
                            r_d.st  = S_ADDR;
                            r_d.idx = '0;
                        end
                    end
                end
                S_ADDR: begin
                    shift_en = 1'b1;
                    if (r_q.idx == IW'(ADDR_NIBS - 1)) r_d.st = S_SIZE;
                    else                                r_d.idx = r_q.idx + 1'b1;
                end
                S_SIZE: begin
                    if (bus_in == SIZE_ONE) begin
                        r_d.st  = S_TAR0;
                        r_d.req = 1'b1;
                        r_d.got = 1'b0;
                    end else begin
                        r_d.st = S_IDLE;
                    end
                end
                S_TAR0:  r_d.st = S_TAR1;
                S_TAR1:  r_d.st = S_WAIT;
                S_WAIT:  if (min_met && (r_q.got || mem_valid)) r_d.st = S_RSYNC;
                S_RSYNC: r_d.st = S_DLO;
                S_DLO:   r_d.st = S_DHI;
                S_DHI:   r_d.st = S_TOUT;
                S_TOUT:  r_d.st = S_IDLE;
                default: r_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= S_IDLE;
            r_q.start_ok <= 1'b0;
            r_q.idx      <= '0;
            r_q.req      <= 1'b0;
            r_q.got      <= 1'b0;
            r_q.data     <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req = r_q.req;

    // R4: the request lasts a single cycle
    p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    // R5: a request only follows a one-byte size nibble
    p_req_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($past(bus_in) == SIZE_ONE));
    // R6: the driver always comes up with the idle nibble
    p_turn_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> (bus_out == NIB_IDLE));
    // R9: the driver releases only after the idle nibble
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe) |-> ($past(bus_out) == NIB_IDLE));
    // R8: ready-sync is followed by the low data nibble
    p_ready_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_RSYNC) |=> (r_q.st == S_DLO && bus_oe));
    // R2: no drive while waiting for a header
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_IDLE) |-> !bus_oe);
endmodule

// File: tb/tb_nbus_read_target.sv
`timescale 1ns/1ps
module tb_nbus_read_target;
    localparam int MIN_WAIT = 2;
    localparam logic [3:0] DEV = 4'hA;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, frame_n, bus_oe, mem_req, mem_valid;
    logic [3:0]  bus_in, bus_out;
    logic [27:0] mem_addr;
    logic [7:0]  mem_data;

    nbus_read_target #(.ADDR_NIBS(7), .MIN_WAIT(MIN_WAIT)) dut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .dev_id(DEV), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data)
    );

    int    cyc = 0, errors = 0, checks = 0, lat = 0;
    bit    mon_on = 0, done = 0;
    string idle_tag = "R9";
    logic [4:0]  exp_bus[int];
    string       exp_tag[int];
    logic [27:0] exp_req[int];

    function automatic logic [7:0] mem_fn(input logic [27:0] a);
        return a[7:0] ^ a[27:20] ^ 8'h3C;
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic check_cycle();
        logic eoe;
        logic [3:0] eout;
        string t;
        eoe = 1'b0; eout = 4'hF; t = idle_tag;
        if (exp_bus.exists(cyc)) begin
            eoe = exp_bus[cyc][4]; eout = exp_bus[cyc][3:0]; t = exp_tag[cyc];
        end
        checks++;
        if (bus_oe !== eoe || (eoe && bus_out !== eout)) begin
            errors++;
            $display("FAIL %s cycle %0d: oe/bus=%b/%h expected %b/%h", t, cyc, bus_oe, bus_out, eoe, eout);
        end
        checks++;
        if (exp_req.exists(cyc)) begin
            if (mem_req !== 1'b1 || mem_addr !== exp_req[cyc]) begin
                errors++;
                $display("FAIL R4 cycle %0d: req/addr=%b/%h expected 1/%h", cyc, mem_req, mem_addr, exp_req[cyc]);
            end
        end else if (mem_req !== 1'b0) begin
            errors++;
            $display("FAIL %s cycle %0d: req=%b expected 0", idle_tag, cyc, mem_req);
        end
    endtask

    // cycle monitor: compares one nanosecond after each rising edge
    initial forever begin
        @(posedge clk);
        cyc++;
        #1;
        if (mon_on && !done) check_cycle();
    end

    // memory model with programmable latency
    initial begin
        bit pend; int cnt; logic [27:0] pa;
        pend = 0; cnt = 0; pa = '0;
        forever begin
            @(negedge clk);
            mem_valid = 1'b0;
            if (mem_req === 1'b1) begin pend = 1; cnt = lat; pa = mem_addr; end
            if (pend) begin
                if (cnt == 0) begin mem_valid = 1'b1; mem_data = mem_fn(pa); pend = 0; end
                else cnt--;
            end
        end
    end

    task automatic read_cycle(input bit pre, input logic [3:0] pre_nib, input logic [3:0] st,
                              input logic [3:0] id, input logic [27:0] a, input logic [3:0] sz,
                              input int l, input string itag);
        int k, lv, tail;
        bit resp;
        logic [7:0] d;
        lat = l; idle_tag = itag;
        if (pre) begin @(negedge clk); frame_n = 1'b0; bus_in = pre_nib; end
        @(negedge clk); frame_n = 1'b0; bus_in = st;
        @(negedge clk); frame_n = 1'b1; bus_in = id;
        for (int i = 6; i >= 0; i--) begin @(negedge clk); bus_in = a[4*i +: 4]; end
        @(negedge clk); bus_in = sz; k = cyc + 1;
        resp = (st == 4'hD) && (id == DEV) && (sz == 4'h0);
        tail = 6;
        if (resp) begin
            d  = mem_fn(a);
            lv = (k + 2 + MIN_WAIT > k + 1 + l) ? k + 2 + MIN_WAIT : k + 1 + l;
            exp_req[k] = a;
            exp_bus[k] = {1'b0, 4'hF};     exp_tag[k] = "R6";
            exp_bus[k+1] = {1'b1, 4'hF};   exp_tag[k+1] = "R6";
            for (int c = k + 2; c < lv; c++) begin exp_bus[c] = {1'b1, 4'h5}; exp_tag[c] = "R7"; end
            exp_bus[lv]   = {1'b1, 4'h0};    exp_tag[lv]   = "R8";
            exp_bus[lv+1] = {1'b1, d[3:0]};  exp_tag[lv+1] = "R8";
            exp_bus[lv+2] = {1'b1, d[7:4]};  exp_tag[lv+2] = "R8";
            exp_bus[lv+3] = {1'b1, 4'hF};    exp_tag[lv+3] = "R9";
            exp_bus[lv+4] = {1'b0, 4'hF};    exp_tag[lv+4] = "R9";
            tail = lv - k + 6;
        end
        @(negedge clk); bus_in = 4'hF;
        repeat (tail) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1; errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; frame_n = 1'b1; bus_in = 4'hF; mem_valid = 1'b0; mem_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        checks++;
        if (bus_oe !== 1'b0 || mem_req !== 1'b0) begin
            errors++;
            $display("FAIL R10: oe/req=%b/%b expected 0/0", bus_oe, mem_req);
        end
        mon_on = 1;
        repeat (2) @(negedge clk);
        // R4 R6 R7 R8 R9: accepted reads at several latencies
        read_cycle(0, 4'h0, 4'hD, DEV, 28'h1234567, 4'h0, 0, "R9");
        read_cycle(0, 4'h0, 4'hD, DEV, 28'hABCDEF0, 4'h0, 5, "R9");
        read_cycle(0, 4'h0, 4'hD, DEV, 28'hFFFFFFF, 4'h0, 1, "R9");
        read_cycle(0, 4'h0, 4'hD, DEV, 28'h0000001, 4'h0, 3, "R7");
        // R3: ID mismatch
        read_cycle(0, 4'h0, 4'hD, 4'h3, 28'h0F0F0F0, 4'h0, 0, "R3");
        // R2: wrong start code
        read_cycle(0, 4'h0, 4'h2, DEV, 28'h1111111, 4'h0, 0, "R2");
        // R5: unsupported size
        read_cycle(0, 4'h0, 4'hD, DEV, 28'h2222222, 4'h1, 0, "R5");
        // R1: last start nibble decides
        read_cycle(1, 4'hD, 4'h2, DEV, 28'h3333333, 4'h0, 0, "R1");
        read_cycle(1, 4'h2, 4'hD, DEV, 28'h4455667, 4'h0, 2, "R1");
        // R1: read code with frame high starts nothing
        idle_tag = "R1";
        repeat (6) begin @(negedge clk); bus_in = 4'hD; end
        @(negedge clk); bus_in = DEV;
        repeat (12) @(negedge clk);
        bus_in = 4'hF;
        read_cycle(0, 4'h0, 4'hD, DEV, 28'h89ABCDE, 4'h0, 0, "R9");
        done = 1;
        summary();
        $finish;
    end
endmodule